// File: doc/BRIEF.md
# Web and Ping Frame Counter Tap

This block sits inline on a byte-wide Ethernet frame stream between a receive port and a transmit port. Every byte passes straight through, with no added latency and no change, while a small parser watches the header bytes as they go by. The parser counts two classes of frame: web frames, which are IPv4 frames carrying TCP with port 80 on either side, and ping frames, which are IPv4 ICMP echo requests. The frame is never buffered.

The offset of the transport header depends on the IPv4 header-length field. The parser stores that field when it arrives and compares the running byte position with the computed transport offset. Each class has its own saturating counter. Software selects one counter onto the read bus and can clear each counter with a one-cycle strobe.

Top module: `wire_tap_classifier`

## Requirements
- R1: Every byte offered on the input is forwarded unchanged. `out_valid`, `out_data`, `out_sof` and `out_eof` equal the matching input signals, and `in_ready` equals `out_ready`, in the same cycle.
- R2: A frame counts as web when all of the following hold: bytes 12 and 13 hold 0x08 and 0x00; the IPv4 version nibble (the upper nibble of byte 14) is 4; the protocol byte 23 is 6; and either the first two transport bytes (source port) or the next two (destination port) hold 0x00 followed by 0x50.
- R3: The header-length value is the lower nibble of byte 14, and the transport header starts at byte 14 + 4 × that value. A frame whose header length is below 5, or whose version is not 4, is counted in neither counter.
- R4: A frame counts as ping when bytes 12–13 and the version follow R2, the protocol byte is 1, and the first transport byte is 8. A first transport byte of 0 (echo reply) is not counted. No frame adds to both counters.
- R5: A frame whose end marker arrives before its deciding byte is counted in neither counter. The deciding byte is the fourth transport byte for TCP and the first transport byte for ICMP.
- R6: A count becomes visible on `rd_data` right after the clock edge that accepts the deciding byte. A byte that is held while `out_ready` is low is not consumed.
- R7: Each counter is `CNT_W` bits wide and stays at all ones once it reaches that value.
- R8: A high `clr_web` or `clr_ping` zeroes the matching counter at the next edge. The clear wins over an increment in the same cycle, and it leaves the other counter alone.
- R9: `rd_sel` = 0 puts the web counter on `rd_data`; `rd_sel` = 1 puts the ping counter there.
- R10: While `rst_n` is low, both counters read zero and parsing restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| rd_sel | input | 1 | Counter select: 0 web, 1 ping |
| rd_data | output | CNT_W | Selected counter value |
| clr_web | input | 1 | Clear strobe for the web counter |
| clr_ping | input | 1 | Clear strobe for the ping counter |

## Verification
The forwarded stream is combinational, so the bench compares the output signals with the inputs 1 ns after it drives them on the falling edge, including stalled cycles. A count is due one edge after the deciding byte is accepted. The bench therefore reads `rd_data` on the falling edge just before that byte's rising edge, where it must still hold the old value, and again on the falling edge just after it, where it must hold the new value. Clear strobes take effect one edge later and are checked the same way. End-of-frame counts are read only after the stream has gone idle.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int IDX_W = 8;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    localparam logic [IDX_W-1:0] ETH_HI_POS = IDX_W'(12);
    localparam logic [IDX_W-1:0] ETH_LO_POS = IDX_W'(13);
    localparam logic [IDX_W-1:0] IP_POS     = IDX_W'(14);
    localparam logic [IDX_W-1:0] PROTO_POS  = IDX_W'(23);

    localparam logic [15:0] ETH_IPV4      = 16'h0800;
    localparam logic [3:0]  IP_VER        = 4'd4;
    localparam logic [3:0]  IHL_MIN       = 4'd5;
    localparam logic [7:0]  PROTO_TCP     = 8'd6;
    localparam logic [7:0]  PROTO_ICMP    = 8'd1;
    localparam logic [15:0] WEB_PORT      = 16'd80;
    localparam logic [7:0]  ICMP_ECHO_REQ = 8'd8;

    localparam int NUM_CNT  = 2;
    localparam int CNT_WEB  = 0;
    localparam int CNT_PING = 1;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             active;
        logic             eth_ok;
        logic             ip_ok;
        logic [3:0]       ihl;
        logic             is_tcp;
        logic             is_icmp;
        logic             hi_zero;
        logic             src_hit;
    } parse_st_t;

endpackage

// File: rtl/wtc_hdr_parser.sv
module wtc_hdr_parser
    import wtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat,
    input  logic       sof,
    input  logic       eof,
    input  logic [7:0] data,
    output logic       web_hit,
    output logic       ping_hit
);

    parse_st_t st_d, st_q;

    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] l4_0, l4_1, l4_2, l4_3;
    logic             live;

    always_comb begin
        l4_0 = IP_POS + IDX_W'({st_q.ihl, 2'b00});
        l4_1 = l4_0 + IDX_W'(1);
        l4_2 = l4_0 + IDX_W'(2);
        l4_3 = l4_0 + IDX_W'(3);
    end

    always_comb begin
        st_d     = st_q;
        web_hit  = 1'b0;
        ping_hit = 1'b0;
        pos      = sof ? '0 : st_q.idx;
        live     = sof | st_q.active;

        if (beat && live) begin
            if (sof) begin
                st_d.eth_ok  = 1'b0;
                st_d.ip_ok   = 1'b0;
                st_d.ihl     = '0;
                st_d.is_tcp  = 1'b0;
                st_d.is_icmp = 1'b0;
                st_d.hi_zero = 1'b0;
                st_d.src_hit = 1'b0;
            end

            // link layer type, big-endian
            if (pos == ETH_HI_POS)
                st_d.eth_ok = (data == ETH_IPV4[15:8]);
            if (pos == ETH_LO_POS)
                st_d.eth_ok = st_q.eth_ok && (data == ETH_IPV4[7:0]);

            // version / header length
            if (pos == IP_POS) begin
                st_d.ihl   = data[3:0];
                st_d.ip_ok = st_q.eth_ok && (data[7:4] == IP_VER)
                             && (data[3:0] >= IHL_MIN);
            end

            // transport protocol
            if (pos == PROTO_POS) begin
                st_d.is_tcp  = st_q.ip_ok && (data == PROTO_TCP);
                st_d.is_icmp = st_q.ip_ok && (data == PROTO_ICMP);
            end

            // ICMP type is the first transport byte
            if (st_q.is_icmp && (pos == l4_0))
                ping_hit = (data == ICMP_ECHO_REQ);

            // TCP ports: source then destination
            if (st_q.is_tcp) begin
                if (pos == l4_0)
                    st_d.hi_zero = (data == WEB_PORT[15:8]);
                if (pos == l4_1)
                    st_d.src_hit = st_q.hi_zero && (data == WEB_PORT[7:0]);
                if (pos == l4_2)
                    st_d.hi_zero = (data == WEB_PORT[15:8]);
                if (pos == l4_3)
                    web_hit = st_q.src_hit
                              || (st_q.hi_zero && (data == WEB_PORT[7:0]));
            end

            st_d.idx    = (pos == IDX_MAX) ? pos : pos + IDX_W'(1);
            st_d.active = !eof;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wtc_sat_counter.sv
module wtc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && (cnt_q != TOP))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wire_tap_classifier.sv
module wire_tap_classifier
    import wtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             clr_web,
    input  logic             clr_ping
);

    logic               beat;
    logic               web_hit, ping_hit;
    logic [NUM_CNT-1:0] hit, clr;
    logic [CNT_W-1:0]   cnt [NUM_CNT];
    logic [CNT_W-1:0]   web_cnt, ping_cnt;

    // straight-through stream path
    assign out_valid = in_valid;
    assign out_data  = in_data;
    assign out_sof   = in_sof;
    assign out_eof   = in_eof;
    assign in_ready  = out_ready;
    assign beat      = in_valid & out_ready;

    wtc_hdr_parser u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .sof      (in_sof),
        .eof      (in_eof),
        .data     (in_data),
        .web_hit  (web_hit),
        .ping_hit (ping_hit)
    );

    always_comb begin
        hit           = '0;
        clr           = '0;
        hit[CNT_WEB]  = web_hit;
        hit[CNT_PING] = ping_hit;
        clr[CNT_WEB]  = clr_web;
        clr[CNT_PING] = clr_ping;
    end

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        wtc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (hit[gi]),
            .clr   (clr[gi]),
            .cnt   (cnt[gi])
        );
    end

    assign web_cnt  = cnt[CNT_WEB];
    assign ping_cnt = cnt[CNT_PING];
    assign rd_data  = rd_sel ? ping_cnt : web_cnt;

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_ready,
    input logic             clr_web,
    input logic             clr_ping,
    input logic [CNT_W-1:0] web_cnt,
    input logic [CNT_W-1:0] ping_cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    // R8: a clear strobe zeroes the counter one edge later
    p_clear_web_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_web |=> (web_cnt == '0));
    p_clear_ping_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ping |=> (ping_cnt == '0));

    // R6: a counter moves by at most one per edge
    p_step_web_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_web |=> ((web_cnt == $past(web_cnt))
                      || (web_cnt == CNT_W'($past(web_cnt) + 1'b1))));

    // R6: nothing is counted on a cycle that moves no byte
    p_no_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && out_ready) && !clr_web && !clr_ping)
        |=> ($stable(web_cnt) && $stable(ping_cnt)));

    // R7: saturation holds
    p_saturate_web_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((web_cnt == TOP) && !clr_web) |=> (web_cnt == TOP));

    // R4: one frame never feeds both counters
    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_web && !clr_ping)
        |=> !((web_cnt != $past(web_cnt)) && (ping_cnt != $past(ping_cnt))));

endmodule

bind wire_tap_classifier wtc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .clr_web   (clr_web),
    .clr_ping  (clr_ping),
    .web_cnt   (web_cnt),
    .ping_cnt  (ping_cnt)
);

// File: tb/wire_tap_classifier_tb.sv
module wire_tap_classifier_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        in_valid, in_sof, in_eof, out_ready;
    logic [7:0]  in_data;
    logic        rd_sel, clr_web, clr_ping;
    logic        in_ready, out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic [31:0] rd_data;
    logic        s_in_ready, s_out_valid, s_out_sof, s_out_eof;
    logic [7:0]  s_out_data;
    logic [2:0]  s_rd_data;

    wire_tap_classifier u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .clr_web(clr_web), .clr_ping(clr_ping)
    );

    // narrow counters for the saturation check
    wire_tap_classifier #(.CNT_W(3)) u_sat (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(s_in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(s_out_valid), .out_ready(out_ready), .out_data(s_out_data),
        .out_sof(s_out_sof), .out_eof(s_out_eof),
        .rd_sel(rd_sel), .rd_data(s_rd_data),
        .clr_web(clr_web), .clr_ping(clr_ping)
    );

    typedef struct packed {
        logic [15:0] etype;
        logic [7:0]  verihl;
        logic [7:0]  proto;
        logic [15:0] sport;
        logic [15:0] dport;
        logic [7:0]  itype;
        logic [7:0]  len;
        logic        web;
        logic        ping;
        logic        stall;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{16'h0800, 8'h45, 8'd6,  16'h1234, 16'h0050, 8'd0, 8'd60, 1'b1, 1'b0, 1'b0}, // R2 dst 80
        '{16'h0800, 8'h45, 8'd6,  16'h0050, 16'hC000, 8'd0, 8'd60, 1'b1, 1'b0, 1'b1}, // R2 src 80, stalls
        '{16'h0800, 8'h45, 8'd6,  16'h1F90, 16'h1F90, 8'd0, 8'd60, 1'b0, 1'b0, 1'b0}, // R2 port 8080
        '{16'h0800, 8'h45, 8'd6,  16'h5000, 16'h5000, 8'd0, 8'd60, 1'b0, 1'b0, 1'b0}, // R2 swapped bytes
        '{16'h0800, 8'h45, 8'd1,  16'h0000, 16'h0000, 8'd8, 8'd60, 1'b0, 1'b1, 1'b1}, // R4 echo request
        '{16'h0800, 8'h45, 8'd1,  16'h0000, 16'h0000, 8'd0, 8'd60, 1'b0, 1'b0, 1'b0}, // R4 echo reply
        '{16'h86DD, 8'h45, 8'd6,  16'h0050, 16'h0050, 8'd0, 8'd60, 1'b0, 1'b0, 1'b0}, // R2 wrong type
        '{16'h0800, 8'h47, 8'd6,  16'h0001, 16'h0050, 8'd0, 8'd64, 1'b1, 1'b0, 1'b1}, // R3 IHL 7
        '{16'h0800, 8'h47, 8'd6,  16'h1111, 16'h2222, 8'd0, 8'd64, 1'b0, 1'b0, 1'b0}, // R3 decoy at byte 34
        '{16'h0800, 8'h65, 8'd6,  16'h0050, 16'h0050, 8'd0, 8'd60, 1'b0, 1'b0, 1'b0}, // R3 version 6
        '{16'h0800, 8'h44, 8'd6,  16'h0050, 16'h0050, 8'd0, 8'd60, 1'b0, 1'b0, 1'b0}, // R3 IHL 4
        '{16'h0800, 8'h45, 8'd6,  16'h0050, 16'h0050, 8'd0, 8'd36, 1'b0, 1'b0, 1'b0}, // R5 short TCP
        '{16'h0800, 8'h4F, 8'd1,  16'h0000, 16'h0000, 8'd8, 8'd80, 1'b0, 1'b1, 1'b1}, // R3 IHL 15 ping
        '{16'h0800, 8'h45, 8'd1,  16'h0000, 16'h0000, 8'd8, 8'd34, 1'b0, 1'b0, 1'b0}, // R5 short ICMP
        '{16'h0800, 8'h45, 8'd17, 16'h0050, 16'h0050, 8'd0, 8'd60, 1'b0, 1'b0, 1'b0}  // R2 UDP
    };

    int n_tests = 0;
    int n_fail  = 0;
    int exp_web = 0;
    int exp_ping = 0;
    logic [7:0] fbuf [128];
    int  cyc = 0;
    int  pt_bad = 0;
    int  watch_idx = -1;
    bit  grab_next = 0;
    longint watch_pre = 0, watch_post = 0;
    longint rw, rp, sw;

    task automatic check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build(vec_t v);
        int ihl = (v.verihl[3:0] < 5) ? 5 : int'(v.verihl[3:0]);
        int l4  = 14 + 4 * ihl;
        for (int i = 0; i < 128; i++) begin
            if (i < 12)                    fbuf[i] = 8'(i + 1);
            else if (i >= 24 && i < 34)    fbuf[i] = 8'hAA;
            else if (i >= 34 && i < l4)    fbuf[i] = (i % 2 == 1) ? 8'h50 : 8'h00;
            else                           fbuf[i] = 8'(i);
        end
        fbuf[12] = v.etype[15:8];
        fbuf[13] = v.etype[7:0];
        fbuf[14] = v.verihl;
        fbuf[23] = v.proto;
        if (v.proto == 8'd1) fbuf[l4] = v.itype;
        else begin
            fbuf[l4]   = v.sport[15:8];
            fbuf[l4+1] = v.sport[7:0];
            fbuf[l4+2] = v.dport[15:8];
            fbuf[l4+3] = v.dport[7:0];
        end
    endtask

    task automatic send(int len, bit stall, int clr_idx);
        int i = 0;
        pt_bad = 0;
        while (i < len) begin
            @(negedge clk);
            if (grab_next) begin watch_post = rd_data; grab_next = 0; end
            in_valid  = 1'b1;
            in_data   = fbuf[i];
            in_sof    = (i == 0);
            in_eof    = (i == len - 1);
            out_ready = !(stall && (cyc % 3 == 2));
            clr_web   = (i == clr_idx) && out_ready;
            cyc++;
            #1;
            if (out_valid !== 1'b1 || out_data !== in_data || out_sof !== in_sof
                || out_eof !== in_eof || in_ready !== out_ready) pt_bad++;
            if (i == watch_idx && out_ready) begin
                watch_pre = rd_data;
                grab_next = 1;
            end
            if (out_ready) i++;
        end
        @(negedge clk);
        if (grab_next) begin watch_post = rd_data; grab_next = 0; end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        clr_web = 1'b0; out_ready = 1'b1;
        #1;
        if (out_valid !== 1'b0) pt_bad++;
    endtask

    task automatic read_cnts();
        @(negedge clk);
        rd_sel = 1'b0; #1; rw = rd_data; sw = s_rd_data;
        rd_sel = 1'b1; #1; rp = rd_data;
        rd_sel = 1'b0;
    endtask

    task automatic web_frame(int clr_idx);
        build('{16'h0800, 8'h45, 8'd6, 16'h2000, 16'h0050, 8'd0, 8'd60, 1'b1, 1'b0, 1'b0});
        send(60, 1'b0, clr_idx);
    endtask

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_data = 8'h00; out_ready = 1'b1; rd_sel = 1'b0;
        clr_web = 1'b0; clr_ping = 1'b0;
        repeat (3) @(negedge clk);
        read_cnts();
        check("R10", "web after reset", rw, 0);
        check("R10", "ping after reset", rp, 0);
        check("R1", "idle out_valid", out_valid, 0);
        @(negedge clk); rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NV; k++) begin
            build(VEC[k]);
            send(int'(VEC[k].len), VEC[k].stall, -1);
            exp_web  += int'(VEC[k].web);
            exp_ping += int'(VEC[k].ping);
            check("R1", $sformatf("vector %0d passthrough mismatches", k), pt_bad, 0);
            read_cnts();
            check("R2", $sformatf("vector %0d web count (R9 sel 0)", k), rw, exp_web);
            check("R4", $sformatf("vector %0d ping count (R9 sel 1)", k), rp, exp_ping);
        end

        // R6: count appears right after the edge taking the deciding byte
        watch_idx = 37;
        web_frame(-1);
        watch_idx = -1;
        exp_web++;
        check("R6", "web before deciding edge", watch_pre, exp_web - 1);
        check("R6", "web after deciding edge", watch_post, exp_web);

        // R7: narrow instance saturates, main keeps counting
        for (int k = 0; k < 4; k++) web_frame(-1);
        exp_web += 4;
        read_cnts();
        check("R2", "web count before saturation check", rw, exp_web);
        check("R7", "3-bit web counter saturated", sw, 7);

        // R8: clear alone
        @(negedge clk); clr_web = 1'b1;
        @(negedge clk); clr_web = 1'b0;
        read_cnts();
        check("R8", "web cleared", rw, 0);
        check("R8", "ping untouched by web clear", rp, exp_ping);
        check("R8", "narrow web cleared", sw, 0);

        // R8: clear coincident with the deciding byte wins
        web_frame(37);
        read_cnts();
        check("R8", "clear beats increment", rw, 0);
        web_frame(-1);
        read_cnts();
        check("R8", "count resumes after clear", rw, 1);

        @(negedge clk); clr_ping = 1'b1;
        @(negedge clk); clr_ping = 1'b0;
        read_cnts();
        check("R8", "ping cleared", rp, 0);
        check("R8", "web untouched by ping clear", rw, 1);

        // R10: reset clears counters
        web_frame(-1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_cnts();
        check("R10", "web after mid-run reset", rw, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule